// File: doc/BRIEF.md
# Phase-Aligned Clock Divider Bank

The block produces eight clock outputs from one input clock. Each output either carries the input clock unchanged or a copy of it divided by an even factor. A divided output with factor D can come up in any one of D phase states. A common restart point removes that ambiguity and gives every output the same, known phase.

A control input `sync_i` sets the restart point. While it is low, every output is held low and every divider counter is cleared. The divide settings may be written only in that state. When `sync_i` goes high, it is first captured by a synchronizer chain clocked by the input clock, so an edge arriving at any moment lands on one defined clock edge. A fixed number of input edges later, all channels start together on the same alignment edge. Every output then has a rising edge at each rising edge of the slowest output, provided the divide factors divide one another. A done flag reports that the bank is running aligned.

Top module: `clk_div_bank`

## Requirements
- R1: After reset, all outputs and `sync_done_o` are low, and every channel's ratio field is 0 (pass-through).
- R2: While `sync_done_o` is low, every bit of `clk_o` is low and the divider counters are held cleared.
- R3: `sync_i` passes through two flip-flops on `clk_i` before the edge counter. If `sync_i` is first sampled high at rising edge A and stays high, `sync_done_o` and the outputs stay low through edge A+5 and start at edge A+6 (the fifth edge after the synchronized sample). The result is the same wherever within the cycle before A the input changed.
- R4: A ratio field value N from 1 to 15 divides by 2N. The output is high for N input cycles, then low for N, and the high half begins on the alignment edge.
- R5: Ratio value 0 selects pass-through: while aligned, the output follows `clk_i` (high while `clk_i` is high, low while it is low).
- R6: After alignment, every divided output whose factor divides that of the slowest output is high at each rising edge of the slowest output.
- R7: A write stores `cfg_ratio_i` into the channel selected by `cfg_sel_i` only while the synchronized `sync_i` and `sync_done_o` are both low. A write made while the bank is aligned is ignored, and the old ratio governs the next alignment.
- R8: `sync_done_o` stays high while `sync_i` stays high. If `sync_i` is first sampled low at edge B, `sync_done_o` is still high after B+1 and is low, with all outputs low, after B+2.
- R9: A `sync_i` pulse that drops before the edge count completes never produces alignment: `sync_done_o` and the outputs stay low.
- R10: `cfg_sel_i` value i (0 to 7) addresses channel i, which drives `clk_o[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock feeding all channels |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Restart control; low holds, rising starts alignment |
| cfg_we_i | input | 1 | Ratio write strobe |
| cfg_sel_i | input | 3 | Channel index for a write |
| cfg_ratio_i | input | 4 | Half divide factor; 0 means pass-through |
| clk_o | output | 8 | Channel clock outputs |
| sync_done_o | output | 1 | High from the alignment edge until the restart control drops |

## Verification
The assertions assume that `clk_i` runs without gaps and that `sync_i` changes at most once per clock period. They also take the ratio fields as the only thing that selects pass-through, so the alignment check ignores channels set to 0. The stimulus changes `sync_i` and the write inputs only at falling edges, or shortly after a rising edge, and never within a setup window. Each aligned run is held long enough to cover many periods of the slowest output before `sync_i` is dropped.

// File: rtl/clk_div_pkg.sv
package clk_div_pkg;
  localparam int unsigned DEF_NUM_CH      = 8;
  localparam int unsigned DEF_RATIO_W     = 4;
  localparam int unsigned DEF_ALIGN_EDGES = 5;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2
  } align_state_e;
endpackage

// File: rtl/sync_align_ctl.sv
module sync_align_ctl
  import clk_div_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int unsigned ALIGN_EDGES = DEF_ALIGN_EDGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic start_o,
  output logic run_o,
  output logic wr_open_o
);
  localparam int unsigned CNT_W = $clog2(ALIGN_EDGES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ALIGN_EDGES - 1);

  logic [SYNC_STAGES-1:0] sync_chain_q;
  logic                   sync_s;
  logic [CNT_W-1:0]       cnt_q;
  align_state_e           state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_chain_q <= '0;
    else         sync_chain_q <= {sync_chain_q[SYNC_STAGES-2:0], sync_i};
  end
  assign sync_s = sync_chain_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
    end else if (!sync_s) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_HOLD, ST_ARM: begin
          if (cnt_q == CNT_LAST) begin
            state_q <= ST_RUN;
          end else begin
            state_q <= ST_ARM;
            cnt_q   <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign run_o     = (state_q == ST_RUN);
  assign start_o   = sync_s && !run_o && (cnt_q == CNT_LAST);
  assign wr_open_o = !sync_s && !run_o;
endmodule

// File: rtl/div_chan.sv
module div_chan #(
  parameter int unsigned RATIO_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [RATIO_W-1:0] wr_ratio_i,
  input  logic               start_i,
  input  logic               run_i,
  output logic               div_q_o,
  output logic               bypass_o,
  output logic [RATIO_W-1:0] ratio_o
);
  logic [RATIO_W-1:0] ratio_q;
  logic [RATIO_W-1:0] cnt_q;
  logic               q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ratio_q <= '0;
    else if (wr_en_i) ratio_q <= wr_ratio_i;
  end

  assign bypass_o = (ratio_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      q_q   <= !bypass_o;  // high half starts on the alignment edge
      cnt_q <= '0;
    end else if (!run_i || bypass_o) begin
      q_q   <= 1'b0;
      cnt_q <= '0;
    end else if (cnt_q == ratio_q - RATIO_W'(1)) begin
      q_q   <= !q_q;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + RATIO_W'(1);
    end
  end

  assign div_q_o = q_q;
  assign ratio_o = ratio_q;
endmodule

// File: rtl/clk_div_bank.sv
module clk_div_bank
  import clk_div_pkg::*;
#(
  parameter int unsigned NUM_CH      = DEF_NUM_CH,
  parameter int unsigned RATIO_W     = DEF_RATIO_W,
  parameter int unsigned ALIGN_EDGES = DEF_ALIGN_EDGES,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sync_i,
  input  logic                      cfg_we_i,
  input  logic [$clog2(NUM_CH)-1:0] cfg_sel_i,
  input  logic [RATIO_W-1:0]        cfg_ratio_i,
  output logic [NUM_CH-1:0]         clk_o,
  output logic                      sync_done_o
);
  localparam int unsigned SEL_W = $clog2(NUM_CH);

  logic                        start;
  logic                        run;
  logic                        wr_open;
  logic [NUM_CH-1:0]           div_q;
  logic [NUM_CH-1:0]           bypass_vec;
  logic [NUM_CH*RATIO_W-1:0]   ratio_flat;

  sync_align_ctl #(
    .SYNC_STAGES(SYNC_STAGES),
    .ALIGN_EDGES(ALIGN_EDGES)
  ) u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sync_i   (sync_i),
    .start_o  (start),
    .run_o    (run),
    .wr_open_o(wr_open)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic wr_en;
    assign wr_en = cfg_we_i && wr_open && (cfg_sel_i == SEL_W'(i));

    div_chan #(.RATIO_W(RATIO_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en),
      .wr_ratio_i(cfg_ratio_i),
      .start_i   (start),
      .run_i     (run),
      .div_q_o   (div_q[i]),
      .bypass_o  (bypass_vec[i]),
      .ratio_o   (ratio_flat[i*RATIO_W +: RATIO_W])
    );

    assign clk_o[i] = run && (bypass_vec[i] ? clk_i : div_q[i]);
  end

  assign sync_done_o = run;
endmodule

// File: rtl/clk_div_bank_chk.sv
module clk_div_bank_chk #(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned RATIO_W = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      sync_i,
  input logic [NUM_CH-1:0]         clk_o,
  input logic                      sync_done_o,
  input logic [NUM_CH-1:0]         div_q,
  input logic [NUM_CH-1:0]         bypass_vec,
  input logic [NUM_CH*RATIO_W-1:0] ratio_flat
);
  // R2
  hold_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_done_o |-> (clk_o == '0));

  // R3
  start_needs_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_done_o) |-> $past(sync_i, 2));

  // R4
  high_half_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_done_o) |-> ((div_q | bypass_vec) == {NUM_CH{1'b1}}));

  // R7
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_done_o |=> $stable(ratio_flat));

  // R8
  stop_needs_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_done_o) |-> !$past(sync_i, 2));
endmodule

bind clk_div_bank clk_div_bank_chk #(
  .NUM_CH (NUM_CH),
  .RATIO_W(RATIO_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sync_i     (sync_i),
  .clk_o      (clk_o),
  .sync_done_o(sync_done_o),
  .div_q      (div_q),
  .bypass_vec (bypass_vec),
  .ratio_flat (ratio_flat)
);

// File: tb/tb_clk_div_bank.sv
`timescale 1ns/1ps
module tb_clk_div_bank;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sync_i = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [2:0] cfg_sel_i = '0;
  logic [3:0] cfg_ratio_i = '0;
  logic [7:0] clk_o;
  logic       sync_done_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  int halves [8];

  always #2 clk_i = ~clk_i;

  clk_div_bank dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_i), .cfg_we_i(cfg_we_i),
    .cfg_sel_i(cfg_sel_i), .cfg_ratio_i(cfg_ratio_i),
    .clk_o(clk_o), .sync_done_o(sync_done_o)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_vec(input int k, input bit clk_high);
    logic [7:0] v;
    for (int c = 0; c < 8; c++)
      v[c] = (halves[c] == 0) ? clk_high : (((k / halves[c]) % 2) == 0);
    return v;
  endfunction

  task automatic wr_ratio(input int ch, input int h);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = 3'(ch); cfg_ratio_i = 4'(h);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  // R3: latency from the first sampling edge
  task automatic sync_up(input bit late_drive);
    if (late_drive) begin
      @(posedge clk_i); #0.5;
    end else begin
      @(negedge clk_i);
    end
    sync_i = 1'b1;
    repeat (6) @(posedge clk_i);
    #1;
    chk(sync_done_o == 1'b0 && clk_o == '0, "R3 early", {7'd0, sync_done_o}, 8'd0);
    @(posedge clk_i); #1;
    chk(sync_done_o == 1'b1, "R3 start", {7'd0, sync_done_o}, 8'd1);
  endtask

  // R4 R5 R6 R10: waveform from alignment edge k=0
  task automatic check_run(input int n_edges, input int slow_ch);
    for (int k = 0; k < n_edges; k++) begin
      if (k > 0) begin @(posedge clk_i); #1; end
      chk(clk_o == exp_vec(k, 1'b1), "R4/R5/R10 high phase", clk_o, exp_vec(k, 1'b1));
      if (slow_ch >= 0 && (k % (2 * halves[slow_ch])) == 0) begin
        logic [7:0] m;
        for (int c = 0; c < 8; c++)
          m[c] = (halves[c] != 0) && ((halves[slow_ch] % halves[c]) == 0);
        chk((clk_o & m) == m, "R6 aligned rise", clk_o & m, m);
      end
      @(negedge clk_i); #1;
      chk(clk_o == exp_vec(k, 1'b0), "R5 low phase", clk_o, exp_vec(k, 1'b0));
    end
  endtask

  // R8 R2: drop timing
  task automatic sync_down();
    @(negedge clk_i);
    sync_i = 1'b0;
    @(posedge clk_i);
    @(posedge clk_i); #1;
    chk(sync_done_o == 1'b1, "R8 still aligned", {7'd0, sync_done_o}, 8'd1);
    @(posedge clk_i); #1;
    chk(sync_done_o == 1'b0 && clk_o == '0, "R8 stopped", clk_o, 8'd0);
    repeat (4) begin
      @(posedge clk_i); #1;
      chk(clk_o == '0, "R2 held low", clk_o, 8'd0);
    end
  endtask

  task automatic t_reset();
    #1;
    chk(clk_o == '0 && sync_done_o == 1'b0, "R1 in reset", clk_o, 8'd0);
    repeat (3) @(posedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(posedge clk_i); #1;
    chk(clk_o == '0 && sync_done_o == 1'b0, "R1 after reset", clk_o, 8'd0);
  endtask

  task automatic t_default_bypass();
    for (int c = 0; c < 8; c++) halves[c] = 0;  // R1: reset ratios are pass-through
    sync_up(1'b0);
    check_run(8, -1);
    sync_down();
  endtask

  task automatic t_set_a();
    int h [8] = '{1, 2, 3, 6, 1, 3, 6, 0};
    for (int c = 0; c < 8; c++) begin halves[c] = h[c]; wr_ratio(c, h[c]); end
    sync_up(1'b0);
    check_run(40, 3);
    sync_down();
  endtask

  task automatic t_set_b_and_ignore();
    int h [8] = '{5, 7, 15, 4, 2, 0, 1, 3};
    for (int c = 0; c < 8; c++) begin halves[c] = h[c]; wr_ratio(c, h[c]); end
    sync_up(1'b0);
    check_run(70, 2);
    wr_ratio(0, 1);  // R7: made while aligned, must be dropped
    wr_ratio(6, 9);
    sync_down();
    sync_up(1'b1);  // R3: late drive in the cycle, same latency
    check_run(40, -1);
    sync_down();
  endtask

  task automatic t_short_pulse();
    @(negedge clk_i);
    sync_i = 1'b1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    sync_i = 1'b0;
    repeat (12) begin
      @(posedge clk_i); #1;
      chk(sync_done_o == 1'b0 && clk_o == '0, "R9 short pulse", clk_o, 8'd0);
    end
  endtask

  initial begin
    t_reset();
    t_default_bypass();
    t_set_a();
    t_set_b_and_ignore();
    t_short_pulse();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule